// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks a singly linked list of 32-bit extended capability headers kept in a configuration-space RAM that sits outside it. Each header packs a 16-bit capability ID, a 4-bit version and a 12-bit byte offset of the following header. The list is always entered at byte offset 0x100. Given a requested ID, the block follows the links through a synchronous RAM read port with one cycle of latency. It reports whether a match was found, the offset of the matching header, and the offset of the header that links to it.

Two uses share the same walk. A search for a nonzero ID locates a capability. A search for the reserved ID 0 never matches, so it always runs to the end of the list and returns the tail offset. In append mode the block finds the tail in the same way. It then splices a new header in at a given offset: it rewrites the tail's link field, and then writes the new header with a zero link. When the new header goes at 0x100 itself, the block reads the link already stored there and keeps it.

Broken links are rejected: a link that is misaligned, below 0x100, or above the space size minus 8. A walk longer than a step limit is also rejected, which guards against loops. In either case the block raises an error flag and writes nothing.

The states are:
- `ST_IDLE`: waits for start.
- `ST_ISSUE`: drives the read address.
- `ST_WAIT`: captures the read word.
- `ST_CHECK`: judges the header.
- `ST_WR_PREV`: rewrites the tail link.
- `ST_WR_NEW`: writes the new header.
- `ST_FINISH`: pulses done.

The transitions are:
- IDLE to ISSUE on start.
- ISSUE to WAIT.
- WAIT to CHECK.
- CHECK to ISSUE when a link is followed.
- CHECK to FINISH on a hit, a miss, an empty list or an error.
- CHECK to WR_PREV at the tail in append mode.
- CHECK to WR_NEW when appending at 0x100.
- WR_PREV to WR_NEW.
- WR_NEW to FINISH.
- FINISH to IDLE.

Top module: `capchain_walker`

## Requirements
- R1: After reset the block is idle: busy, done, found, bad_link, mem_rd_en and mem_wr_en are all 0.
- R2: start is taken only while busy is 0; a start during a walk has no effect on its result. done is high for exactly one cycle, and found, bad_link, hit_off and prev_off are valid in that cycle.
- R3: A header word holds the ID in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. The walk begins at 0x100, and a next offset of 0 ends it.
- R4: A search for a nonzero ID that matches a header returns found=1, hit_off set to that header's offset, and prev_off set to the offset of the header linking to it (0 when the match is at 0x100). This holds even when the matching header is also the tail.
- R5: A search for a nonzero ID with no match returns found=0, hit_off=0 and prev_off set to the tail offset.
- R6: A header of all zeros at 0x100 means an empty list. A search then returns found=0, hit_off=0 and prev_off=0 after exactly one RAM read.
- R7: A search for ID 0 never matches and returns found=0, hit_off=0 and prev_off set to the tail offset.
- R8: A next offset that is not a multiple of 4, or is below 0x100, or is above SPACE_BYTES-8 (0xFF8 by default) gives bad_link=1, found=0, hit_off set to the offset of the header holding that link, and prev_off=0. No RAM write is made. 0xFF8 itself is accepted.
- R9: A walk that would visit more than MAX_STEPS headers ends with bad_link=1 and no RAM write.
- R10: Appending at an offset other than 0x100 performs two writes, in order:
  - the tail word, with bits 31:20 replaced by new_off and bits 19:0 kept;
  - the word {12'h000, new_ver, cap_id} at new_off.
  Done then reports hit_off=new_off, prev_off=tail and bad_link=0.
- R11: Appending at 0x100 reads the word there and writes {its bits 31:20, new_ver, cap_id} back to 0x100. It reports hit_off=0x100 and prev_off=0.
- R12: Appending at an offset other than 0x100 to an empty list gives bad_link=1, hit_off=0 and prev_off=0, and makes no RAM write.
- R13: Reads and writes never occur in the same cycle, and a read is never issued in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| append_mode | input | 1 | 1 = append a header, 0 = search |
| cap_id | input | 16 | ID to search for, or ID of the new header |
| new_off | input | 12 | Byte offset of the new header (append) |
| new_ver | input | 4 | Version of the new header (append) |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_addr | output | 12 | RAM byte address for read or write |
| mem_wdata | output | 32 | RAM write word |
| mem_rdata | input | 32 | RAM read word, valid one cycle after the read |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Search matched |
| bad_link | output | 1 | Broken link, loop, or append to an empty list |
| hit_off | output | 12 | Matching offset, or the new header's offset |
| prev_off | output | 12 | Offset of the preceding or tail header |

## Verification
Two pairs of this block's functions can coincide in one cycle.

The first pair is a match and the end of the chain. The header at 0x200 carries both the requested ID and a zero link. The vector table searches for it and expects the hit to win, with prev_off naming the header before it rather than the tail.

The second pair is a new start arriving while a walk is under way. The bench raises start with a different ID two cycles into a search. It judges that the completion still reports the first ID's match and that done stays a single-cycle pulse.

// File: rtl/capchain_pkg.sv
package capchain_pkg;

    localparam int OFF_W = 12;
    localparam int ID_W  = 16;
    localparam int VER_W = 4;
    localparam int HDR_W = OFF_W + VER_W + ID_W;

    typedef struct packed {
        logic [OFF_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } cap_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_CHECK,
        ST_WR_PREV,
        ST_WR_NEW,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [2:0] {
        CK_HEAD_WRITE,
        CK_EMPTY,
        CK_HIT,
        CK_TAIL,
        CK_BAD,
        CK_FOLLOW
    } check_e;

endpackage

// File: rtl/capchain_link_check.sv
module capchain_link_check
    import capchain_pkg::*;
#(
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096
) (
    input  logic [OFF_W-1:0] link,
    output logic             link_ok
);
    localparam logic [OFF_W-1:0] LO = OFF_W'(BASE_OFF);
    localparam logic [OFF_W-1:0] HI = OFF_W'(SPACE_BYTES - 8);

    always_comb begin
        link_ok = (link[1:0] == 2'b00) && (link >= LO) && (link <= HI);
    end
endmodule

// File: rtl/capchain_step_guard.sv
module capchain_step_guard #(
    parameter int LIMIT = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        at_limit = (cnt_q == CNT_W'(LIMIT - 1));
    end
endmodule

// File: rtl/capchain_walker.sv
module capchain_walker
    import capchain_pkg::*;
#(
    parameter int SPACE_BYTES = 4096,
    parameter int BASE_OFF    = 256,
    parameter int MAX_STEPS   = 960
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             append_mode,
    input  logic [ID_W-1:0]  cap_id,
    input  logic [OFF_W-1:0] new_off,
    input  logic [VER_W-1:0] new_ver,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [OFF_W-1:0] mem_addr,
    output logic [HDR_W-1:0] mem_wdata,
    input  logic [HDR_W-1:0] mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic             bad_link,
    output logic [OFF_W-1:0] hit_off,
    output logic [OFF_W-1:0] prev_off
);
    localparam logic [OFF_W-1:0] BASE_A = OFF_W'(BASE_OFF);

    walk_state_e      st_q, st_d;
    check_e           ck;
    cap_hdr_t         hdr_q;
    logic [OFF_W-1:0] cur_q, prv_q, new_q;
    logic [ID_W-1:0]  id_q;
    logic [VER_W-1:0] ver_q;
    logic             app_q;
    logic             res_found, res_err;
    logic [OFF_W-1:0] res_hit, res_prev;
    logic             link_ok, at_limit, step_clr, step_inc;
    logic             head_app, list_empty;

    capchain_link_check #(
        .BASE_OFF   (BASE_OFF),
        .SPACE_BYTES(SPACE_BYTES)
    ) u_link (
        .link   (hdr_q.nxt),
        .link_ok(link_ok)
    );

    capchain_step_guard #(
        .LIMIT(MAX_STEPS)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (step_clr),
        .inc     (step_inc),
        .at_limit(at_limit)
    );

    // Judgement of the captured header; meaningful in ST_CHECK.
    always_comb begin
        head_app   = app_q && (new_q == BASE_A);
        list_empty = (cur_q == BASE_A) && (hdr_q == '0);
        if (head_app) begin
            ck = CK_HEAD_WRITE;
        end else if (list_empty) begin
            ck = CK_EMPTY;
        end else if (!app_q && (id_q != '0) && (hdr_q.id == id_q)) begin
            ck = CK_HIT;
        end else if (hdr_q.nxt == '0) begin
            ck = CK_TAIL;
        end else if (!link_ok || at_limit) begin
            ck = CK_BAD;
        end else begin
            ck = CK_FOLLOW;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = ST_ISSUE;
            ST_ISSUE:   st_d = ST_WAIT;
            ST_WAIT:    st_d = ST_CHECK;
            ST_CHECK: begin
                unique case (ck)
                    CK_HEAD_WRITE: st_d = ST_WR_NEW;
                    CK_TAIL:       st_d = app_q ? ST_WR_PREV : ST_FINISH;
                    CK_FOLLOW:     st_d = ST_ISSUE;
                    default:       st_d = ST_FINISH;
                endcase
            end
            ST_WR_PREV: st_d = ST_WR_NEW;
            ST_WR_NEW:  st_d = ST_FINISH;
            ST_FINISH:  st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Walk datapath and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q     <= '0;
            cur_q     <= '0;
            prv_q     <= '0;
            new_q     <= '0;
            id_q      <= '0;
            ver_q     <= '0;
            app_q     <= 1'b0;
            res_found <= 1'b0;
            res_err   <= 1'b0;
            res_hit   <= '0;
            res_prev  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        app_q     <= append_mode;
                        id_q      <= cap_id;
                        new_q     <= new_off;
                        ver_q     <= new_ver;
                        cur_q     <= BASE_A;
                        prv_q     <= '0;
                        res_found <= 1'b0;
                        res_err   <= 1'b0;
                        res_hit   <= '0;
                        res_prev  <= '0;
                    end
                end
                ST_WAIT: hdr_q <= mem_rdata;
                ST_CHECK: begin
                    unique case (ck)
                        CK_HEAD_WRITE: begin
                            res_hit  <= BASE_A;
                            res_prev <= '0;
                        end
                        CK_EMPTY: res_err <= app_q;
                        CK_HIT: begin
                            res_found <= 1'b1;
                            res_hit   <= cur_q;
                            res_prev  <= prv_q;
                        end
                        CK_TAIL: begin
                            res_hit  <= app_q ? new_q : '0;
                            res_prev <= cur_q;
                        end
                        CK_BAD: begin
                            res_err  <= 1'b1;
                            res_hit  <= cur_q;
                            res_prev <= '0;
                        end
                        default: begin
                            prv_q <= cur_q;
                            cur_q <= hdr_q.nxt;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            ST_ISSUE: begin
                mem_rd_en = 1'b1;
                mem_addr  = cur_q;
            end
            ST_WR_PREV: begin
                mem_wr_en = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = {new_q, hdr_q.ver, hdr_q.id};
            end
            ST_WR_NEW: begin
                mem_wr_en = 1'b1;
                mem_addr  = new_q;
                mem_wdata = {(head_app ? hdr_q.nxt : {OFF_W{1'b0}}), ver_q, id_q};
            end
            default: ;
        endcase
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_FINISH);
        step_clr = (st_q == ST_IDLE);
        step_inc = (st_q == ST_CHECK) && (ck == CK_FOLLOW);
        found    = res_found;
        bad_link = res_err;
        hit_off  = res_hit;
        prev_off = res_prev;
    end
endmodule

// File: rtl/capchain_walker_chk.sv
module capchain_walker_chk #(
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        found,
    input logic        bad_link,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [11:0] mem_addr
);
    localparam logic [11:0] LO = 12'(BASE_OFF);
    localparam logic [11:0] HI = 12'(SPACE_BYTES - 8);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R2
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R13
    AST_NO_BACK_TO_BACK_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R13
    AST_RD_IN_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr[1:0] == 2'b00 && mem_addr >= LO && mem_addr <= HI)); // R8
    AST_HIT_NOT_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> !bad_link); // R4
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd_en || mem_wr_en)); // R1
endmodule

bind capchain_walker capchain_walker_chk #(
    .BASE_OFF   (BASE_OFF),
    .SPACE_BYTES(SPACE_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .found    (found),
    .bad_link (bad_link),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .mem_addr (mem_addr)
);

// File: tb/capchain_walker_tb.sv
module capchain_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        append_mode = 1'b0;
    logic [15:0] cap_id = '0;
    logic [11:0] new_off = '0;
    logic [3:0]  new_ver = '0;
    logic        mem_rd_en, mem_wr_en;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        busy, done, found, bad_link;
    logic [11:0] hit_off, prev_off;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int overlap_cnt = 0;

    logic [31:0] ram [0:1023];
    logic        poke_en = 1'b0;
    logic [11:0] poke_addr = '0;
    logic [31:0] poke_data = '0;

    logic        r_found, r_err;
    logic [11:0] r_hit, r_prev;

    always #2.5 clk = ~clk;

    capchain_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .append_mode(append_mode),
        .cap_id(cap_id), .new_off(new_off), .new_ver(new_ver),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .found(found), .bad_link(bad_link), .hit_off(hit_off), .prev_off(prev_off)
    );

    // RAM model: one-cycle read latency, plus a bench-side poke port.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) ram[i] <= '0;
            mem_rdata <= '0;
        end else begin
            if (mem_rd_en) begin
                mem_rdata <= ram[mem_addr[11:2]];
                rd_cnt <= rd_cnt + 1;
            end
            if (mem_wr_en) begin
                ram[mem_addr[11:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (mem_rd_en && mem_wr_en) overlap_cnt <= overlap_cnt + 1;
            if (poke_en) ram[poke_addr[11:2]] <= poke_data;
        end
    end

    // {id[15:0], found[3:0], hit[11:0], prev[11:0]} for the chain
    // 0x100(id 1) -> 0x140(id 3) -> 0x200(id 0xB, tail)
    localparam logic [43:0] VEC [0:4] = '{
        {16'h0001, 4'h1, 12'h100, 12'h000},  // R4 hit at the head
        {16'h0003, 4'h1, 12'h140, 12'h100},  // R4 hit in the middle
        {16'h000B, 4'h1, 12'h200, 12'h140},  // R4 hit on the tail
        {16'h0007, 4'h0, 12'h000, 12'h200},  // R5 miss
        {16'h0000, 4'h0, 12'h000, 12'h200}   // R7 tail search
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = addr; poke_data = data;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic run(input logic app, input logic [15:0] id, input logic [11:0] off,
                       input logic [3:0] ver);
        bit got = 0;
        @(negedge clk);
        append_mode = app; cap_id = id; new_off = off; new_ver = ver; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            if (done) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
        if (!got) begin
            errors++;
            checks++;
            $display("FAIL R2 no done actual=0 expected=1");
        end
        r_found = found; r_err = bad_link; r_hit = hit_off; r_prev = prev_off;
        @(negedge clk);
        check("R2 done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic expect_res(input string tag, input logic f, input logic e,
                              input logic [11:0] h, input logic [11:0] p);
        check({tag, " found"}, {31'd0, r_found}, {31'd0, f});
        check({tag, " bad_link"}, {31'd0, r_err}, {31'd0, e});
        check({tag, " hit_off"}, {20'd0, r_hit}, {20'd0, h});
        check({tag, " prev_off"}, {20'd0, r_prev}, {20'd0, p});
    endtask

    task automatic load_chain();
        poke(12'h100, 32'h1400_0001);
        poke(12'h140, 32'h2000_0003);
        poke(12'h200, 32'h0001_000B);
    endtask

    // Watchdog
    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rd0, wr0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 found", {31'd0, found}, 32'd0);
        check("R1 bad_link", {31'd0, bad_link}, 32'd0);
        check("R1 rd_en", {31'd0, mem_rd_en}, 32'd0);
        check("R1 wr_en", {31'd0, mem_wr_en}, 32'd0);

        // R3 R4 R5 R7 vector table over one chain
        load_chain();
        for (int v = 0; v < 5; v++) begin
            wr0 = wr_cnt;
            run(1'b0, VEC[v][43:28], 12'h000, 4'h0);
            expect_res("R3 vector", VEC[v][24], 1'b0, VEC[v][23:12], VEC[v][11:0]);
            check("R5 search writes nothing", wr_cnt - wr0, 0);
        end

        // R2 start while busy is ignored
        @(negedge clk);
        append_mode = 1'b0; cap_id = 16'h0003; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        cap_id = 16'h0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 100 && !done; n++) @(negedge clk);
        check("R2 late start ignored hit_off", {20'd0, hit_off}, 32'h140);
        @(negedge clk);
        check("R2 done drops", {31'd0, done}, 32'd0);

        // R10 append at 0x300
        run(1'b1, 16'h0010, 12'h300, 4'h2);
        expect_res("R10 append", 1'b0, 1'b0, 12'h300, 12'h200);
        check("R10 tail rewritten", ram[12'h200 >> 2], 32'h3001_000B);
        check("R10 new header", ram[12'h300 >> 2], 32'h0002_0010);
        run(1'b0, 16'h0010, 12'h000, 4'h0);
        expect_res("R10 new entry found", 1'b1, 1'b0, 12'h300, 12'h200);

        // R11 append at the head keeps the existing link
        run(1'b1, 16'h0020, 12'h100, 4'h1);
        expect_res("R11 head append", 1'b0, 1'b0, 12'h100, 12'h000);
        check("R11 head word", ram[12'h100 >> 2], 32'h1401_0020);
        run(1'b0, 16'h0001, 12'h000, 4'h0);
        expect_res("R5 replaced id missing", 1'b0, 1'b0, 12'h000, 12'h300);

        // R6 empty list
        poke(12'h100, 32'h0000_0000);
        rd0 = rd_cnt;
        run(1'b0, 16'h0001, 12'h000, 4'h0);
        expect_res("R6 empty", 1'b0, 1'b0, 12'h000, 12'h000);
        check("R6 single read", rd_cnt - rd0, 1);

        // R12 append elsewhere on an empty list
        wr0 = wr_cnt;
        run(1'b1, 16'h0005, 12'h180, 4'h0);
        expect_res("R12 empty append", 1'b0, 1'b1, 12'h000, 12'h000);
        check("R12 no write", wr_cnt - wr0, 0);

        // R11 head append on an empty list
        run(1'b1, 16'h0030, 12'h100, 4'h3);
        check("R11 empty head word", ram[12'h100 >> 2], 32'h0003_0030);

        // R8 broken links
        wr0 = wr_cnt;
        poke(12'h100, 32'h1420_0001);
        run(1'b0, 16'h0009, 12'h000, 4'h0);
        expect_res("R8 misaligned", 1'b0, 1'b1, 12'h100, 12'h000);
        run(1'b1, 16'h0007, 12'h300, 4'h0);
        check("R8 append on bad link", {31'd0, r_err}, 32'd1);
        poke(12'h100, 32'h0800_0001);
        run(1'b0, 16'h0009, 12'h000, 4'h0);
        expect_res("R8 below base", 1'b0, 1'b1, 12'h100, 12'h000);
        poke(12'h100, 32'hFFC0_0001);
        run(1'b0, 16'h0009, 12'h000, 4'h0);
        expect_res("R8 above top", 1'b0, 1'b1, 12'h100, 12'h000);
        check("R8 no write", wr_cnt - wr0, 0);
        poke(12'h100, 32'hFF80_0001);
        poke(12'hFF8, 32'h0000_0005);
        run(1'b0, 16'h0005, 12'h000, 4'h0);
        expect_res("R8 top boundary accepted", 1'b1, 1'b0, 12'hFF8, 12'h100);

        // R9 self loop hits the step guard
        wr0 = wr_cnt;
        poke(12'h100, 32'h1000_0001);
        run(1'b0, 16'h0009, 12'h000, 4'h0);
        expect_res("R9 loop guard", 1'b0, 1'b1, 12'h100, 12'h000);
        check("R9 no write", wr_cnt - wr0, 0);

        // R13 read/write overlap
        check("R13 no overlap", overlap_cnt, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule